// File: doc/BRIEF.md
# Lockable Software Peripheral Reset Control

This block lets software hold a small set of peripherals in reset. Each peripheral has its own channel, and each channel has two bits. The first is an active-low control bit. A 0 holds that peripheral in reset and a 1 releases it. The second is a lock bit. Writing 0 to it freezes the control bit. Nothing short of a block reset can undo the lock.

Each channel's reset output is the control bit combined with three hardware reset sources: a lifecycle request, a system request and power-on reset. Any active hardware source forces every peripheral reset low, whatever software has written.

Software reaches the block through a plain register bus. The bus has a read strobe, a write strobe, a word address, write data, read data and an error flag. Read data and the error flag are combinational in the cycle of the access. A write takes effect at the clock edge that samples it.

Top module: `swrst_ctrl`

## Requirements
- R1: After reset, every lock bit and every control bit is 1. With no hardware source active, every `periph_rst_n` output is 1.
- R2: Writing the lock register at offset 0x10 clears channel n's lock bit when `wdata[n]` is 0. A 1 leaves the bit as it is. A cleared lock bit stays 0 until the block is reset.
- R3: A write to the control register at offset 0x14 leaves unchanged the control bit, and the output, of every channel whose lock bit is 0. Unlocked channels in the same write still update.
- R4: For an unlocked channel n, a control write loads `wdata[n]` into its control bit at the sampling edge. From then on, `periph_rst_n[n]` is low for 0 and high for 1, provided no hardware source is active.
- R5: While `lc_rst_req` is 1, or `sys_rst_req` is 1, or `por_n` is 0, every `periph_rst_n` output is 0 in the same cycle, whatever the control bits hold.
- R6: A read of offset 0x10 returns the lock bits, and a read of offset 0x14 returns the control bits. In both, channel n is at bit n and all other bits are 0. Neither read raises `err`.
- R7: A read or write at any other offset raises `err` in that cycle and returns read data 0. Such a write changes no lock or control bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Active-low block reset |
| re | input | 1 | Read strobe |
| we | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid in the cycle of `re` |
| err | output | 1 | Access to an unmapped offset |
| lc_rst_req | input | 1 | Lifecycle reset request, active high |
| sys_rst_req | input | 1 | System reset request, active high |
| por_n | input | 1 | Power-on reset, active low |
| periph_rst_n | output | NUM_CHAN | Peripheral resets, active low |

## Verification
Two things can fall in the same cycle: a software control write and a change on a hardware reset source. The bench provokes this by issuing a control write with 0s while `lc_rst_req` is high. It checks that the outputs are low during that cycle because of the hardware source. After the request drops, it checks that the outputs show the newly written control value, masked by the locks. The control write is not lost while the hardware source holds the outputs low. The bench also sweeps all four lock patterns. For each one it tries every control value and all eight combinations of hardware sources. Each output is compared with the value computed from the control model ANDed with the hardware-source state.

// File: rtl/swrst_pkg.sv
package swrst_pkg;
  // Register selected by the current bus access
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LOCK = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_BAD  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/swrst_decode.sv
module swrst_decode
  import swrst_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter logic [ADDR_W-1:0] LOCK_OFS = 5'h10,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 5'h14
) (
  input  logic              re,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic              lock_we,
  output logic              ctrl_we,
  output logic              bus_err
);
  always_comb begin
    sel = SEL_NONE;
    if (re || we) begin
      if (addr == LOCK_OFS)      sel = SEL_LOCK;
      else if (addr == CTRL_OFS) sel = SEL_CTRL;
      else                       sel = SEL_BAD;
    end
  end

  assign lock_we = we && (sel == SEL_LOCK);
  assign ctrl_we = we && (sel == SEL_CTRL);
  assign bus_err = (sel == SEL_BAD);
endmodule

// File: rtl/swrst_chan.sv
module swrst_chan (
  input  logic clk,
  input  logic rst_ni,
  input  logic lock_we,
  input  logic lock_wd,
  input  logic ctrl_we,
  input  logic ctrl_wd,
  input  logic hw_hold,
  output logic lock_q,
  output logic ctrl_q,
  output logic rst_n
);
  // Lock bit: a written 0 clears it; nothing but reset sets it again
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b1;
    end else if (lock_we && !lock_wd) begin
      lock_q <= 1'b0;
    end
  end

  // Control bit: writable only while the lock bit is still set
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= 1'b1;
    end else if (ctrl_we && lock_q) begin
      ctrl_q <= ctrl_wd;
    end
  end

  assign rst_n = ctrl_q & ~hw_hold;
endmodule

// File: rtl/swrst_rdmux.sv
module swrst_rdmux
  import swrst_pkg::*;
#(
  parameter int unsigned NUM_CHAN = 2,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                re,
  input  reg_sel_e            sel,
  input  logic [NUM_CHAN-1:0] lock_vec,
  input  logic [NUM_CHAN-1:0] ctrl_vec,
  output logic [DATA_W-1:0]   rdata
);
  localparam int unsigned PAD_W = DATA_W - NUM_CHAN;

  always_comb begin
    rdata = '0;
    if (re) begin
      unique case (sel)
        SEL_LOCK: rdata = {{PAD_W{1'b0}}, lock_vec};
        SEL_CTRL: rdata = {{PAD_W{1'b0}}, ctrl_vec};
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/swrst_ctrl.sv
module swrst_ctrl
  import swrst_pkg::*;
#(
  parameter int unsigned NUM_CHAN = 2,
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned DATA_W   = 32,
  parameter logic [ADDR_W-1:0] LOCK_OFS = 5'h10,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 5'h14
) (
  input  logic                clk,
  input  logic                rst_ni,
  input  logic                re,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  output logic                err,
  input  logic                lc_rst_req,
  input  logic                sys_rst_req,
  input  logic                por_n,
  output logic [NUM_CHAN-1:0] periph_rst_n
);
  reg_sel_e            sel;
  logic                lock_we;
  logic                ctrl_we;
  logic                hw_hold;
  logic [NUM_CHAN-1:0] lock_q;
  logic [NUM_CHAN-1:0] ctrl_q;
  logic                unused_wdata_hi;

  assign unused_wdata_hi = ^wdata[DATA_W-1:NUM_CHAN];
  assign hw_hold = lc_rst_req | sys_rst_req | ~por_n;

  swrst_decode #(
    .ADDR_W  (ADDR_W),
    .LOCK_OFS(LOCK_OFS),
    .CTRL_OFS(CTRL_OFS)
  ) u_decode (
    .re     (re),
    .we     (we),
    .addr   (addr),
    .sel    (sel),
    .lock_we(lock_we),
    .ctrl_we(ctrl_we),
    .bus_err(err)
  );

  for (genvar gi = 0; gi < NUM_CHAN; gi++) begin : g_chan
    swrst_chan u_chan (
      .clk    (clk),
      .rst_ni (rst_ni),
      .lock_we(lock_we),
      .lock_wd(wdata[gi]),
      .ctrl_we(ctrl_we),
      .ctrl_wd(wdata[gi]),
      .hw_hold(hw_hold),
      .lock_q (lock_q[gi]),
      .ctrl_q (ctrl_q[gi]),
      .rst_n  (periph_rst_n[gi])
    );
  end

  swrst_rdmux #(
    .NUM_CHAN(NUM_CHAN),
    .DATA_W  (DATA_W)
  ) u_rdmux (
    .re      (re),
    .sel     (sel),
    .lock_vec(lock_q),
    .ctrl_vec(ctrl_q),
    .rdata   (rdata)
  );
endmodule

// File: rtl/swrst_ctrl_chk.sv
module swrst_ctrl_chk #(
  parameter int unsigned NUM_CHAN = 2,
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned DATA_W   = 32,
  parameter logic [ADDR_W-1:0] LOCK_OFS = 5'h10,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 5'h14
) (
  input logic                clk,
  input logic                rst_ni,
  input logic                re,
  input logic                we,
  input logic [ADDR_W-1:0]   addr,
  input logic [DATA_W-1:0]   wdata,
  input logic [DATA_W-1:0]   rdata,
  input logic                err,
  input logic                lc_rst_req,
  input logic                sys_rst_req,
  input logic                por_n,
  input logic [NUM_CHAN-1:0] periph_rst_n,
  input logic [NUM_CHAN-1:0] lock_q,
  input logic [NUM_CHAN-1:0] ctrl_q
);
  localparam int unsigned PAD_W = DATA_W - NUM_CHAN;

  // R2
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (lock_q & ~$past(lock_q)) == '0);

  // R3
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ((ctrl_q ^ $past(ctrl_q)) & ~$past(lock_q)) == '0);

  // R4
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (we && addr == CTRL_OFS) |=>
      ctrl_q == (($past(wdata[NUM_CHAN-1:0]) & $past(lock_q)) |
                 ($past(ctrl_q) & ~$past(lock_q))));

  // R5
  hw_source_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (lc_rst_req || sys_rst_req || !por_n) |-> periph_rst_n == '0);

  // R6
  lock_read_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (re && addr == LOCK_OFS) |-> (!err && rdata == {{PAD_W{1'b0}}, lock_q}));

  // R7
  unmapped_err_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ((re || we) && addr != LOCK_OFS && addr != CTRL_OFS) |-> (err && rdata == '0));
endmodule

bind swrst_ctrl swrst_ctrl_chk #(
  .NUM_CHAN(NUM_CHAN),
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .LOCK_OFS(LOCK_OFS),
  .CTRL_OFS(CTRL_OFS)
) u_chk (
  .clk         (clk),
  .rst_ni      (rst_ni),
  .re          (re),
  .we          (we),
  .addr        (addr),
  .wdata       (wdata),
  .rdata       (rdata),
  .err         (err),
  .lc_rst_req  (lc_rst_req),
  .sys_rst_req (sys_rst_req),
  .por_n       (por_n),
  .periph_rst_n(periph_rst_n),
  .lock_q      (lock_q),
  .ctrl_q      (ctrl_q)
);

// File: tb/swrst_ctrl_tb.sv
module swrst_ctrl_tb;
  localparam int unsigned NC = 2;
  localparam int unsigned AW = 5;
  localparam int unsigned DW = 32;
  localparam logic [AW-1:0] A_LOCK = 5'h10;
  localparam logic [AW-1:0] A_CTRL = 5'h14;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          re = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          err;
  logic          lc_rst_req = 1'b0;
  logic          sys_rst_req = 1'b0;
  logic          por_n = 1'b1;
  logic [NC-1:0] periph_rst_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [NC-1:0] lock_m;
  logic [NC-1:0] ctrl_m;

  always #5 clk = ~clk;

  swrst_ctrl u_dut (
    .clk(clk), .rst_ni(rst_ni), .re(re), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .err(err), .lc_rst_req(lc_rst_req),
    .sys_rst_req(sys_rst_req), .por_n(por_n), .periph_rst_n(periph_rst_n)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    lock_m = '1;
    ctrl_m = '1;
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 we = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic e);
    @(negedge clk);
    re = 1'b1; addr = a;
    #1 d = rdata; e = err;
    re = 1'b0;
  endtask

  function automatic logic [NC-1:0] exp_out();
    return (lc_rst_req || sys_rst_req || !por_n) ? '0 : ctrl_m;
  endfunction

  initial begin
    logic [DW-1:0] d;
    logic e;
    for (int lp = 0; lp < 4; lp++) begin
      do_reset();
      // R1: reset state
      #1 check("R1 outputs after reset", DW'(periph_rst_n), DW'(2'b11));
      bus_read(A_LOCK, d, e);
      check("R1/R6 lock read after reset", d, 32'h3);
      check("R6 no err on lock read", DW'(e), '0);
      bus_read(A_CTRL, d, e);
      check("R1/R6 ctrl read after reset", d, 32'h3);
      // R2: clear chosen locks, then try to set them again
      bus_write(A_LOCK, DW'(~lp[1:0]) | 32'hFFFF_FFFC);
      lock_m = ~lp[1:0];
      bus_write(A_LOCK, 32'hFFFF_FFFF);
      bus_read(A_LOCK, d, e);
      check("R2 lock sticky", d, DW'(lock_m));
      // R3/R4: sweep control values and hardware sources
      for (int v = 0; v < 4; v++) begin
        bus_write(A_CTRL, DW'(v) | 32'hA5A5_A5A0);
        ctrl_m = (v[1:0] & lock_m) | (ctrl_m & ~lock_m);
        check("R3/R4 output after ctrl write", DW'(periph_rst_n), DW'(exp_out()));
        bus_read(A_CTRL, d, e);
        check("R3/R6 ctrl readback", d, DW'(ctrl_m));
        for (int h = 0; h < 8; h++) begin
          @(negedge clk);
          lc_rst_req = h[0]; sys_rst_req = h[1]; por_n = ~h[2];
          #1 check("R5 hw source merge", DW'(periph_rst_n), DW'(exp_out()));
        end
        @(negedge clk);
        lc_rst_req = 1'b0; sys_rst_req = 1'b0; por_n = 1'b1;
      end
      // Same-cycle: ctrl write while lifecycle request active
      @(negedge clk);
      lc_rst_req = 1'b1; we = 1'b1; addr = A_CTRL; wdata = '0;
      #1 check("R5 outputs low during concurrent write", DW'(periph_rst_n), '0);
      @(posedge clk);
      #1 we = 1'b0;
      ctrl_m = ctrl_m & ~lock_m;
      @(negedge clk);
      lc_rst_req = 1'b0;
      #1 check("R4 concurrent write retained", DW'(periph_rst_n), DW'(ctrl_m));
      // R7: unmapped accesses
      bus_read(5'h18, d, e);
      check("R7 unmapped read data", d, '0);
      check("R7 unmapped read err", DW'(e), 32'h1);
      @(negedge clk);
      we = 1'b1; addr = 5'h11; wdata = '0;
      #1 check("R7 unmapped write err", DW'(err), 32'h1);
      @(posedge clk);
      #1 we = 1'b0;
      bus_read(A_LOCK, d, e);
      check("R7 lock untouched by unmapped write", d, DW'(lock_m));
      bus_read(A_CTRL, d, e);
      check("R7 ctrl untouched by unmapped write", d, DW'(ctrl_m));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule